// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block takes the instruction word sitting at the current program counter and works out where fetch should go next. It handles 16-bit control-transfer encodings for a 14-bit word-addressed program space: short-reach conditional branches that test one chosen status flag, long-reach relative jumps and calls, two-word absolute jumps and calls, jumps and calls through a 16-bit pointer register, and the two return forms. Any other word simply advances the counter by one.

It is purely combinational and sits between the fetch stage and the stack logic. Alongside the next counter value it reports whether control was redirected. For calls it raises a push request together with the return address to save. For returns it raises a pop request and takes the popped address from an input. The interrupt-return form also hands back a status byte with the global interrupt-enable bit forced on.

Top module: `npc_unit`

## Requirements
- R1: A word with bits 15..13 = 110 and bit 12 = 0 is a relative jump: pcNext = pcCur + 1 + sign-extended bits 11..0, taken = 1, with no push and no pop.
- R2: A word with bits 15..13 = 110 and bit 12 = 1 is a relative call: the same target as R1, plus pushReq = 1 with pushValue = pcCur + 1.
- R3: A word with bits 15..11 = 11110 is a conditional branch. Bits 2..0 pick the status bit (0 = C, 1 = Z, 2 = N, 3 = V, 4 = S, 5 = H, 6 = T, 7 = I). Bit 10 = 0 branches when that bit is 1, and bit 10 = 1 branches when it is 0. When the branch is taken, pcNext = pcCur + 1 + sign-extended bits 9..3 and taken = 1.
- R4: A branch whose condition fails, and any word that is not a control transfer (for example 0x0000), gives pcNext = pcCur + 1 and taken = 0, with no push and no pop.
- R5: A first word matching 1001 010x xxxx 110x is a direct jump: pcNext = bits 13..0 of instrNext and taken = 1. The first word's own address bits are ignored.
- R6: A first word matching 1001 010x xxxx 111x is a direct call: the same target as R5, plus pushReq = 1 with pushValue = pcCur + 2.
- R7: The word 0x9409 jumps to bits 13..0 of ptrReg. The word 0x9509 does the same and also pushes pcCur + 1.
- R8: The words 0x9508 and 0x9518 set popReq = 1 and pcNext = popValue. Only 0x9518 sets bit 7 of statusOut. In every other case statusOut equals statusIn.
- R9: Every computed address wraps modulo 2^14.
- R10: pushReq and popReq are never both high, and each of them implies taken = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pcCur | input | 14 | Address of the word being decoded |
| instrWord | input | 16 | Instruction word at pcCur |
| instrNext | input | 16 | Word at pcCur + 1, used as an absolute target |
| statusIn | input | 8 | Current status flags |
| ptrReg | input | 16 | Pointer register for indirect transfers |
| popValue | input | 14 | Address popped from the stack |
| pcNext | output | 14 | Next program counter |
| taken | output | 1 | Control was redirected |
| pushReq | output | 1 | Return address must be pushed |
| pushValue | output | 14 | Return address to push |
| popReq | output | 1 | Return address must be popped |
| statusOut | output | 8 | Status after the word executes |

## Verification
The embedded assertions check four things whenever the inputs change. At most one decode class matches a word. The push and pop requests keep their exclusivity and imply a redirect. A word that does not redirect advances the counter by exactly one. The status output differs from its input in the interrupt-enable bit alone.

Only the bench's scenarios can confirm the values themselves. These are the actual targets of each addressing form, the mapping from selector value to status bit, the sense of the set/clear bit, the return address being one or two words ahead, and wrap at both ends of the address space.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int PC_WIDTH     = 14;
  localparam int WORD_WIDTH   = 16;
  localparam int FLAG_WIDTH   = 8;
  localparam int PTR_WIDTH    = 16;
  localparam int LONG_OFF_W   = 12;
  localparam int SHORT_OFF_W  = 7;
  localparam int LONG_OFF_LSB = 0;
  localparam int SHORT_OFF_LSB = 3;

  // Fixed opcodes
  localparam logic [15:0] OPC_RETURN     = 16'h9508;
  localparam logic [15:0] OPC_RETURN_INT = 16'h9518;
  localparam logic [15:0] OPC_PTR_JUMP   = 16'h9409;
  localparam logic [15:0] OPC_PTR_CALL   = 16'h9509;

  // Pattern matching: (word & mask) == match
  localparam logic [15:0] REL_MASK    = 16'hE000;
  localparam logic [15:0] REL_MATCH   = 16'hC000;
  localparam logic [15:0] COND_MASK   = 16'hF800;
  localparam logic [15:0] COND_MATCH  = 16'hF000;
  localparam logic [15:0] ABS_MASK    = 16'hFE0E;
  localparam logic [15:0] ABS_JMATCH  = 16'h940C;
  localparam logic [15:0] ABS_CMATCH  = 16'h940E;

  typedef enum logic [2:0] {
    TGT_STEP,
    TGT_REL_LONG,
    TGT_REL_SHORT,
    TGT_ABS,
    TGT_PTR,
    TGT_POP
  } tgtSel_e;

  typedef enum logic {
    LINK_STEP1,
    LINK_STEP2
  } linkSel_e;

  typedef struct packed {
    tgtSel_e  tgtSel;
    linkSel_e linkSel;
    logic     taken;
    logic     push;
    logic     pop;
    logic     setIntEn;
  } ctrlStrobe_t;

endpackage

// File: rtl/npc_offset_add.sv
module npc_offset_add #(
  parameter int PcW  = 14,
  parameter int OffW = 12
) (
  input  logic [PcW-1:0]  base,
  input  logic [OffW-1:0] offset,
  output logic [PcW-1:0]  sum
);

  logic [PcW-1:0] offExt;

  generate
    if (PcW > OffW) begin : g_extend
      assign offExt = {{(PcW-OffW){offset[OffW-1]}}, offset};
    end else begin : g_trunc
      assign offExt = offset[PcW-1:0];
    end
  endgenerate

  assign sum = base + offExt;

endmodule

// File: rtl/npc_control.sv
module npc_control
  import npc_pkg::*;
#(
  parameter int WordW = WORD_WIDTH,
  parameter int FlagW = FLAG_WIDTH
) (
  input  logic [WordW-1:0] instrWord,
  input  logic [FlagW-1:0] statusIn,
  output ctrlStrobe_t      strobe
);

  localparam int SelW     = $clog2(FlagW);
  localparam int SenseBit = 10;
  localparam int CallBit  = 12;

  logic isRel, isCond, isAbsJmp, isAbsCall;
  logic isPtrJmp, isPtrCall, isRet, isReti;
  logic [SelW-1:0] flagSel;
  logic flagVal, condHit;

  assign isRel     = (instrWord & REL_MASK)  == REL_MATCH;
  assign isCond    = (instrWord & COND_MASK) == COND_MATCH;
  assign isAbsJmp  = (instrWord & ABS_MASK)  == ABS_JMATCH;
  assign isAbsCall = (instrWord & ABS_MASK)  == ABS_CMATCH;
  assign isPtrJmp  = instrWord == OPC_PTR_JUMP;
  assign isPtrCall = instrWord == OPC_PTR_CALL;
  assign isRet     = instrWord == OPC_RETURN;
  assign isReti    = instrWord == OPC_RETURN_INT;

  assign flagSel = instrWord[SelW-1:0];
  assign flagVal = statusIn[flagSel];
  // sense bit 0: branch on set, 1: branch on clear
  assign condHit = flagVal ^ instrWord[SenseBit];

  always_comb begin
    strobe = '{tgtSel: TGT_STEP, linkSel: LINK_STEP1,
               taken: 1'b0, push: 1'b0, pop: 1'b0, setIntEn: 1'b0};
    if (isRel) begin
      strobe.tgtSel = TGT_REL_LONG;
      strobe.taken  = 1'b1;
      strobe.push   = instrWord[CallBit];
    end else if (isCond) begin
      if (condHit) begin
        strobe.tgtSel = TGT_REL_SHORT;
        strobe.taken  = 1'b1;
      end
    end else if (isAbsJmp || isAbsCall) begin
      strobe.tgtSel  = TGT_ABS;
      strobe.taken   = 1'b1;
      strobe.push    = isAbsCall;
      strobe.linkSel = LINK_STEP2;
    end else if (isPtrJmp || isPtrCall) begin
      strobe.tgtSel = TGT_PTR;
      strobe.taken  = 1'b1;
      strobe.push   = isPtrCall;
    end else if (isRet || isReti) begin
      strobe.tgtSel   = TGT_POP;
      strobe.taken    = 1'b1;
      strobe.pop      = 1'b1;
      strobe.setIntEn = isReti;
    end
  end

  always_comb begin
    AST_ONE_CLASS: assert ($onehot0({isRel, isCond, isAbsJmp, isAbsCall,
                                     isPtrJmp, isPtrCall, isRet, isReti}))
      else $error("decode classes overlap"); // R3
    AST_STROBE_SANE: assert (!(strobe.push && strobe.pop)
                             && (!(strobe.push || strobe.pop) || strobe.taken))
      else $error("push/pop strobes inconsistent"); // R10
  end

endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int PcW       = PC_WIDTH,
  parameter int WordW     = WORD_WIDTH,
  parameter int FlagW     = FLAG_WIDTH,
  parameter int PtrW      = PTR_WIDTH,
  parameter int LongOffW  = LONG_OFF_W,
  parameter int LongLsb   = LONG_OFF_LSB,
  parameter int ShortOffW = SHORT_OFF_W,
  parameter int ShortLsb  = SHORT_OFF_LSB
) (
  input  ctrlStrobe_t      strobe,
  input  logic [PcW-1:0]   pcCur,
  input  logic [WordW-1:0] instrWord,
  input  logic [WordW-1:0] instrNext,
  input  logic [PtrW-1:0]  ptrReg,
  input  logic [PcW-1:0]   popValue,
  input  logic [FlagW-1:0] statusIn,
  output logic [PcW-1:0]   pcNext,
  output logic [PcW-1:0]   pushValue,
  output logic [FlagW-1:0] statusOut
);

  localparam int IntBit = FlagW - 1;
  localparam logic [PcW-1:0]   ONE     = PcW'(1);
  localparam logic [PcW-1:0]   TWO     = PcW'(2);
  localparam logic [FlagW-1:0] INT_BIT = FlagW'(1) << IntBit;

  logic [PcW-1:0] step1, step2, relLong, relShort;
  logic [PcW-1:0] linkDelta;

  assign step1 = pcCur + ONE;
  assign step2 = pcCur + TWO;

  npc_offset_add #(.PcW(PcW), .OffW(LongOffW)) u_addLong (
    .base  (step1),
    .offset(instrWord[LongLsb +: LongOffW]),
    .sum   (relLong)
  );

  npc_offset_add #(.PcW(PcW), .OffW(ShortOffW)) u_addShort (
    .base  (step1),
    .offset(instrWord[ShortLsb +: ShortOffW]),
    .sum   (relShort)
  );

  always_comb begin
    unique case (strobe.tgtSel)
      TGT_REL_LONG:  pcNext = relLong;
      TGT_REL_SHORT: pcNext = relShort;
      TGT_ABS:       pcNext = instrNext[PcW-1:0];
      TGT_PTR:       pcNext = ptrReg[PcW-1:0];
      TGT_POP:       pcNext = popValue;
      default:       pcNext = step1;
    endcase
  end

  assign pushValue = (strobe.linkSel == LINK_STEP2) ? step2 : step1;
  assign statusOut = strobe.setIntEn ? (statusIn | INT_BIT) : statusIn;

  assign linkDelta = pushValue - pcCur;

  logic unusedHiBits;
  assign unusedHiBits = ^{instrNext[WordW-1:PcW], ptrReg[PtrW-1:PcW]};

  always_comb begin
    AST_LINK_AHEAD: assert (linkDelta == ONE || linkDelta == TWO)
      else $error("return address not one or two words ahead"); // R6
    AST_FLAGS_KEPT: assert ((statusOut & ~INT_BIT) == (statusIn & ~INT_BIT))
      else $error("status bits other than interrupt enable changed"); // R8
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int PcW   = PC_WIDTH,
  parameter int WordW = WORD_WIDTH,
  parameter int FlagW = FLAG_WIDTH,
  parameter int PtrW  = PTR_WIDTH
) (
  input  logic [PcW-1:0]   pcCur,
  input  logic [WordW-1:0] instrWord,
  input  logic [WordW-1:0] instrNext,
  input  logic [FlagW-1:0] statusIn,
  input  logic [PtrW-1:0]  ptrReg,
  input  logic [PcW-1:0]   popValue,
  output logic [PcW-1:0]   pcNext,
  output logic             taken,
  output logic             pushReq,
  output logic [PcW-1:0]   pushValue,
  output logic             popReq,
  output logic [FlagW-1:0] statusOut
);

  ctrlStrobe_t strobe;

  npc_control #(.WordW(WordW), .FlagW(FlagW)) u_control (
    .instrWord(instrWord),
    .statusIn (statusIn),
    .strobe   (strobe)
  );

  npc_datapath #(.PcW(PcW), .WordW(WordW), .FlagW(FlagW), .PtrW(PtrW)) u_datapath (
    .strobe   (strobe),
    .pcCur    (pcCur),
    .instrWord(instrWord),
    .instrNext(instrNext),
    .ptrReg   (ptrReg),
    .popValue (popValue),
    .statusIn (statusIn),
    .pcNext   (pcNext),
    .pushValue(pushValue),
    .statusOut(statusOut)
  );

  assign taken   = strobe.taken;
  assign pushReq = strobe.push;
  assign popReq  = strobe.pop;

  always_comb begin
    AST_FALLTHROUGH_STEP: assert (taken || pcNext == pcCur + PcW'(1))
      else $error("fall-through did not advance by one"); // R4
    AST_POP_TARGET: assert (!popReq || pcNext == popValue)
      else $error("return did not use popped address"); // R8
    AST_NO_PUSH_POP: assert (!(pushReq && popReq))
      else $error("push and pop together"); // R10
  end

endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [13:0] pcCur;
  logic [15:0] instrWord, instrNext, ptrReg;
  logic [7:0]  statusIn;
  logic [13:0] popValue;
  logic [13:0] pcNext, pushValue;
  logic        taken, pushReq, popReq;
  logic [7:0]  statusOut;

  npc_unit u_npc_unit (
    .pcCur(pcCur), .instrWord(instrWord), .instrNext(instrNext),
    .statusIn(statusIn), .ptrReg(ptrReg), .popValue(popValue),
    .pcNext(pcNext), .taken(taken), .pushReq(pushReq),
    .pushValue(pushValue), .popReq(popReq), .statusOut(statusOut)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [13:0] pc;
    logic [15:0] word;
    logic [15:0] word2;
    logic [7:0]  st;
    logic [15:0] ptr;
    logic [13:0] popv;
    logic [13:0] eNext;
    logic        eTaken;
    logic        ePush;
    logic [13:0] ePushVal;
    logic        ePop;
    logic [7:0]  eStat;
  } vec_t;

  localparam int NUM_VEC = 16;
  localparam vec_t VECS [NUM_VEC] = '{
    // R1 backward relative jump
    '{8'd1, 14'h0206, 16'hCF1C, 16'h0000, 8'h00, 16'h0000, 14'h0000, 14'h0123, 1'b1, 1'b0, 14'h0000, 1'b0, 8'h00},
    // R2 relative call
    '{8'd2, 14'h0100, 16'hD010, 16'h0000, 8'h00, 16'h0000, 14'h0000, 14'h0111, 1'b1, 1'b1, 14'h0101, 1'b0, 8'h00},
    // R3 branch on Z set, Z=1
    '{8'd3, 14'h0112, 16'hF081, 16'h0000, 8'h02, 16'h0000, 14'h0000, 14'h0123, 1'b1, 1'b0, 14'h0000, 1'b0, 8'h02},
    // R4 same branch, Z=0
    '{8'd4, 14'h0112, 16'hF081, 16'h0000, 8'h00, 16'h0000, 14'h0000, 14'h0113, 1'b0, 1'b0, 14'h0000, 1'b0, 8'h00},
    // R3 branch on C clear, most negative offset
    '{8'd3, 14'h0050, 16'hF600, 16'h0000, 8'h00, 16'h0000, 14'h0000, 14'h0011, 1'b1, 1'b0, 14'h0000, 1'b0, 8'h00},
    // R5 direct jump
    '{8'd5, 14'h0300, 16'h940C, 16'h1234, 8'h00, 16'h0000, 14'h0000, 14'h1234, 1'b1, 1'b0, 14'h0000, 1'b0, 8'h00},
    // R5 direct jump with high address bits set in first word
    '{8'd5, 14'h0300, 16'h95FD, 16'h0042, 8'h00, 16'h0000, 14'h0000, 14'h0042, 1'b1, 1'b0, 14'h0000, 1'b0, 8'h00},
    // R6 direct call to top of space
    '{8'd6, 14'h0400, 16'h940E, 16'h3FFF, 8'h00, 16'h0000, 14'h0000, 14'h3FFF, 1'b1, 1'b1, 14'h0402, 1'b0, 8'h00},
    // R6 direct call at last word, return address wraps
    '{8'd6, 14'h3FFF, 16'h940F, 16'h0100, 8'h00, 16'h0000, 14'h0000, 14'h0100, 1'b1, 1'b1, 14'h0001, 1'b0, 8'h00},
    // R7 indirect jump
    '{8'd7, 14'h0010, 16'h9409, 16'h0000, 8'h00, 16'h2ABC, 14'h0000, 14'h2ABC, 1'b1, 1'b0, 14'h0000, 1'b0, 8'h00},
    // R7 indirect call, pointer high bits dropped
    '{8'd7, 14'h0020, 16'h9509, 16'h0000, 8'h00, 16'hC001, 14'h0000, 14'h0001, 1'b1, 1'b1, 14'h0021, 1'b0, 8'h00},
    // R8 plain return keeps status
    '{8'd8, 14'h0030, 16'h9508, 16'h0000, 8'h05, 16'h0000, 14'h0777, 14'h0777, 1'b1, 1'b0, 14'h0000, 1'b1, 8'h05},
    // R8 interrupt return sets bit 7
    '{8'd8, 14'h0030, 16'h9518, 16'h0000, 8'h05, 16'h0000, 14'h1000, 14'h1000, 1'b1, 1'b0, 14'h0000, 1'b1, 8'h85},
    // R9 forward relative jump wraps past top
    '{8'd9, 14'h3FFF, 16'hC001, 16'h0000, 8'h00, 16'h0000, 14'h0000, 14'h0001, 1'b1, 1'b0, 14'h0000, 1'b0, 8'h00},
    // R9 branch on I set, offset -1 at address 0
    '{8'd9, 14'h0000, 16'hF3FF, 16'h0000, 8'h80, 16'h0000, 14'h0000, 14'h0000, 1'b1, 1'b0, 14'h0000, 1'b0, 8'h80},
    // R4 non-control word at last address wraps
    '{8'd4, 14'h3FFF, 16'h0000, 16'h0000, 8'h3C, 16'h0000, 14'h0000, 14'h0000, 1'b0, 1'b0, 14'h0000, 1'b0, 8'h3C}
  };

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic drive(input vec_t v);
    @(negedge clk);
    pcCur = v.pc; instrWord = v.word; instrNext = v.word2;
    statusIn = v.st; ptrReg = v.ptr; popValue = v.popv;
    #2;
  endtask

  task automatic checkVec(input vec_t v, input int idx);
    logic pushOk;
    checks++;
    pushOk = (pushReq == v.ePush) && (!v.ePush || pushValue == v.ePushVal);
    if (pcNext !== v.eNext || taken !== v.eTaken || !pushOk ||
        popReq !== v.ePop || statusOut !== v.eStat) begin
      errors++;
      $display("FAIL R%0d vec %0d: next=%h taken=%b push=%b/%h pop=%b st=%h expected next=%h taken=%b push=%b/%h pop=%b st=%h",
               v.req, idx, pcNext, taken, pushReq, pushValue, popReq, statusOut,
               v.eNext, v.eTaken, v.ePush, v.ePushVal, v.ePop, v.eStat);
    end
  endtask

  initial begin
    pcCur = '0; instrWord = '0; instrNext = '0;
    statusIn = '0; ptrReg = '0; popValue = '0;
    #2;
    // R4 idle inputs: all-zero word falls through
    checks++;
    if (pcNext !== 14'h0001 || taken !== 1'b0 || pushReq !== 1'b0 || popReq !== 1'b0) begin
      errors++;
      $display("FAIL R4 idle: next=%h taken=%b push=%b pop=%b expected next=0001 taken=0 push=0 pop=0",
               pcNext, taken, pushReq, popReq);
    end

    for (int i = 0; i < NUM_VEC; i++) begin
      drive(VECS[i]);
      checkVec(VECS[i], i);
    end

    // R3 every selector, both senses, flag high and low; other flags opposite
    for (int sel = 0; sel < 8; sel++) begin
      for (int sense = 0; sense < 2; sense++) begin
        for (int fv = 0; fv < 2; fv++) begin
          vec_t v;
          logic expT;
          v = '0;
          v.req  = 8'd3;
          v.pc   = 14'h0200;
          v.word = 16'hF000 | (16'(sense) << 10) | (16'h05 << 3) | 16'(sel);
          v.st   = fv ? (8'h01 << sel) : ~(8'h01 << sel);
          expT   = (fv != sense);
          v.eTaken = expT;
          v.eNext  = expT ? 14'h0206 : 14'h0201;
          v.eStat  = v.st;
          drive(v);
          checkVec(v, 100 + sel * 4 + sense * 2 + fv);
        end
      end
    end

    // R10 across all classes, push and pop never together
    for (int i = 0; i < NUM_VEC; i++) begin
      drive(VECS[i]);
      checks++;
      if ((pushReq && popReq) || ((pushReq || popReq) && !taken)) begin
        errors++;
        $display("FAIL R10 vec %0d: push=%b pop=%b taken=%b expected exclusive and taken",
                 i, pushReq, popReq, taken);
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule